// File: doc/BRIEF.md
# Branch Trace Packet Generator

This block sits beside a processor core and turns its stream of retired control-flow events into a compact byte stream. A software decoder reads that stream together with the program image and rebuilds the path that ran. It accepts one event per cycle. Plain instructions produce nothing. Conditional branches add one direction bit to a batch. Indirect branches produce a target packet. Interrupts and exceptions produce a flow-update packet that carries the source address, followed by a target packet. Execution-width changes produce a mode packet.

Addresses are compressed against the last address placed in the stream, so only the low bytes that differ are sent. Packets are staged into a 16-byte output FIFO, and each packet is either written whole or not at all. When a packet does not fit, it is dropped, along with every later packet of the same cycle. An overflow marker then goes out as soon as one byte of room exists. After an overflow the address reference is cleared, so the decoder can resynchronize from a full address.

Top module: `bt_trace_gen`

## Requirements
- R1: A cycle with no event, or with a plain-instruction event (kind 0), writes no byte unless an overflow marker is pending.
- R2: A conditional event (kind 1) never produces an address. It shifts one bit (1 = taken) into a batch. On the sixth bit a direction byte is written. A direction byte has bit 7 set. Its highest set bit among bits 6..0 is a stop bit at position n, where n is the number of bits, and below the stop bit the n bits appear oldest-first from high to low.
- R3: A partial direction batch is written as its own direction byte ahead of any target, flow-update or mode packet in the same cycle, and the batch then restarts empty.
- R4: An indirect event (kind 2) writes a target packet. Its header is 0x10 plus the compression code, followed by the sent address bytes, lowest byte first.
- R5: The compression code is 0 if the address equals the reference (no bytes sent), 1 if bits 63..16 match (2 bytes sent), 2 if bits 63..32 match (4 bytes sent), and 3 otherwise (8 bytes sent). After the packet the reference becomes the full address.
- R6: An interrupt or exception event (kind 3) writes a flow-update packet first: header 0x20 plus code, carrying the source compressed against the reference. It then writes a target packet whose address is compressed against that source.
- R7: A mode event (kind 4) with a width code (0 = 16-bit, 1 = 32-bit, 2 = 64-bit) that differs from the current width writes 0x30 followed by the code byte. The width after reset is 2. An unchanged width, or code 3, writes nothing.
- R8: A packet that does not fit in the free FIFO space is dropped, together with all later packets of that cycle. A single 0x40 marker is then written ahead of anything else, in the first cycle with at least one free byte.
- R9: The first address packet after reset, and the first one after an overflow, always uses code 3.
- R10: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_valid` hold. Bytes leave in the order they were written.
- R11: During and right after reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | An event is present this cycle |
| ev_kind | input | 3 | 0 plain, 1 conditional, 2 indirect, 3 interrupt/exception, 4 mode |
| ev_taken | input | 1 | Direction of a conditional event |
| ev_src | input | 64 | Source address of an interrupt/exception |
| ev_tgt | input | 64 | Destination address of an indirect or interrupt/exception event |
| ev_mode | input | 2 | New width code of a mode event |
| out_valid | output | 1 | A trace byte is available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | Trace byte |

## Verification
The embedded properties assume at most one event per cycle. They also assume that `ev_kind` only takes the five defined codes, and that the consumer does not depend on `out_byte` unless `out_valid` is high. The bench drives each event for exactly one cycle, just after a clock edge, and uses only the defined codes. Between cases it drains the FIFO, so fill levels are known. In the overflow cases it holds `out_ready` low on purpose, so that the drop point and the position of the marker follow from counted packet lengths.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int ADDR_W      = 64;
    localparam int ADDR_BYTES  = ADDR_W / 8;
    localparam int DIR_BATCH   = 6;                    // bits per direction byte
    localparam int PKT_BYTES   = 1 + ADDR_BYTES;       // longest single packet
    localparam int STAGE_BYTES = 2 + 2 * PKT_BYTES;    // marker + dir + two address packets
    localparam int LEN_W       = $clog2(PKT_BYTES + 1);

    typedef enum logic [2:0] {
        EV_SEQ   = 3'd0,
        EV_COND  = 3'd1,
        EV_INDIR = 3'd2,
        EV_ASYNC = 3'd3,
        EV_MODE  = 3'd4
    } ev_kind_e;

    typedef enum logic [2:0] {
        OP_TGT  = 3'd1,
        OP_SRC  = 3'd2,
        OP_MODE = 3'd3,
        OP_OVF  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        IPC_SAME = 2'd0,
        IPC_LO2  = 2'd1,
        IPC_LO4  = 2'd2,
        IPC_FULL = 2'd3
    } ipc_e;

    typedef struct packed {
        logic [LEN_W-1:0]       len;
        logic [PKT_BYTES*8-1:0] data;   // byte 0 in the low bits
    } pkt_t;

    function automatic logic [7:0] hdr(input op_e op, input logic [1:0] sub);
        return {1'b0, op, 2'b00, sub};
    endfunction

    function automatic ipc_e ip_code(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] ref_a,
                                     input logic ref_ok);
        if (!ref_ok)                              return IPC_FULL;
        if (a == ref_a)                           return IPC_SAME;
        if (a[ADDR_W-1:16] == ref_a[ADDR_W-1:16]) return IPC_LO2;
        if (a[ADDR_W-1:32] == ref_a[ADDR_W-1:32]) return IPC_LO4;
        return IPC_FULL;
    endfunction

    function automatic logic [LEN_W-1:0] ipc_len(input ipc_e c);
        case (c)
            IPC_SAME: return LEN_W'(0);
            IPC_LO2:  return LEN_W'(2);
            IPC_LO4:  return LEN_W'(4);
            default:  return LEN_W'(ADDR_BYTES);
        endcase
    endfunction

    function automatic pkt_t ip_pkt(input op_e op,
                                    input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] ref_a,
                                    input logic ref_ok);
        pkt_t p;
        ipc_e c;
        c      = ip_code(a, ref_a, ref_ok);
        p.data = {a, hdr(op, c)};
        p.len  = LEN_W'(1) + ipc_len(c);
        return p;
    endfunction

    function automatic pkt_t short_pkt(input logic [7:0] b0, input logic [7:0] b1,
                                       input logic [LEN_W-1:0] n);
        pkt_t p;
        p.data = {{(PKT_BYTES*8-16){1'b0}}, b1, b0};
        p.len  = n;
        return p;
    endfunction

endpackage

// File: rtl/bt_dir_batch.sv
module bt_dir_batch
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic       taken,
    input  logic       flush,
    output logic       emit,
    output logic [7:0] tnt_byte
);
    localparam int CNT_W = $clog2(DIR_BATCH + 1);

    logic [CNT_W-1:0]     cnt_q;
    logic [DIR_BATCH-1:0] bits_q;
    logic [DIR_BATCH-1:0] bits_nx;

    always_comb begin
        bits_nx  = {bits_q[DIR_BATCH-2:0], taken};
        emit     = 1'b0;
        tnt_byte = 8'h00;
        if (push && cnt_q == CNT_W'(DIR_BATCH - 1)) begin
            emit     = 1'b1;
            tnt_byte = {2'b11, bits_nx};
        end else if (flush && cnt_q != '0) begin
            emit     = 1'b1;
            tnt_byte = 8'h80 | (8'h01 << cnt_q) | 8'(bits_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bits_q <= '0;
        end else if (emit) begin
            cnt_q  <= '0;
            bits_q <= '0;
        end else if (push) begin
            cnt_q  <= cnt_q + CNT_W'(1);
            bits_q <= bits_nx;
        end
    end

    // R2
    tnt_form_chk: assert property (@(posedge clk) disable iff (rst)
        emit |-> (tnt_byte[7] && tnt_byte[6:0] != 7'd0));

    // R3
    batch_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && !push && cnt_q != '0) |=> (cnt_q == '0));

endmodule

// File: rtl/bt_byte_fifo.sv
module bt_byte_fifo #(
    parameter int DEPTH = 16,      // power of two
    parameter int WMAX  = 20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(WMAX+1)-1:0]    wr_cnt,
    input  logic [WMAX*8-1:0]            wr_data,
    output logic [$clog2(DEPTH+1)-1:0]   free,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [7:0]                   out_byte
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          pop;

    assign out_valid = (cnt_q != '0);
    assign out_byte  = mem[rp_q];
    assign pop       = out_valid && out_ready;
    assign free      = CW'(DEPTH) - cnt_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < WMAX; i++) begin
            if (i < int'(wr_cnt)) mem[wp_q + AW'(i)] <= wr_data[i*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_q + AW'(wr_cnt);
            rp_q  <= rp_q + AW'(pop);
            cnt_q <= cnt_q + CW'(wr_cnt) - CW'(pop);
        end
    end

    // R8
    fifo_room_chk: assert property (@(posedge clk) disable iff (rst)
        int'(wr_cnt) <= int'(free));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

endmodule

// File: rtl/bt_trace_gen.sv
module bt_trace_gen
    import bt_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_valid,
    input  logic [2:0]  ev_kind,
    input  logic        ev_taken,
    input  logic [63:0] ev_src,
    input  logic [63:0] ev_tgt,
    input  logic [1:0]  ev_mode,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_byte
);
    localparam int WC_W   = $clog2(STAGE_BYTES + 1);
    localparam int FREE_W = $clog2(FIFO_DEPTH + 1);
    localparam int N_CAND = 4;   // marker, direction, flow-update/mode, target

    ev_kind_e                kind;
    logic                    is_cond, is_ind, is_async, mode_chg, flush;
    logic [ADDR_W-1:0]       last_q;
    logic                    last_ok_q, ovf_q;
    logic [1:0]              mode_q;
    logic                    tnt_emit;
    logic [7:0]              tnt_byte;
    logic [FREE_W-1:0]       free;
    logic [WC_W-1:0]         wr_cnt;
    logic [STAGE_BYTES*8-1:0] wr_data;
    logic                    dropped;
    pkt_t                    cand [N_CAND];
    logic [N_CAND-1:0]       cand_en;
    logic [7:0]              stage [STAGE_BYTES];
    int                      pos;

    assign kind     = ev_kind_e'(ev_kind);
    assign is_cond  = ev_valid && kind == EV_COND;
    assign is_ind   = ev_valid && kind == EV_INDIR;
    assign is_async = ev_valid && kind == EV_ASYNC;
    assign mode_chg = ev_valid && kind == EV_MODE && ev_mode != mode_q && ev_mode != 2'd3;
    assign flush    = is_ind || is_async || mode_chg;

    bt_dir_batch u_dir (
        .clk      (clk),
        .rst      (rst),
        .push     (is_cond),
        .taken    (ev_taken),
        .flush    (flush),
        .emit     (tnt_emit),
        .tnt_byte (tnt_byte)
    );

    // Candidate packets in stream order.
    always_comb begin
        cand_en = {is_ind || is_async, is_async || mode_chg, tnt_emit, ovf_q};
        cand[0] = short_pkt(hdr(OP_OVF, 2'b00), 8'h00, LEN_W'(1));
        cand[1] = short_pkt(tnt_byte, 8'h00, LEN_W'(1));
        cand[2] = is_async ? ip_pkt(OP_SRC, ev_src, last_q, last_ok_q)
                           : short_pkt(hdr(OP_MODE, 2'b00), {6'd0, ev_mode}, LEN_W'(2));
        cand[3] = ip_pkt(OP_TGT, ev_tgt, is_async ? ev_src : last_q, is_async || last_ok_q);
    end

    // Whole-packet placement: first packet that misses ends the cycle's writes.
    always_comb begin
        pos     = 0;
        dropped = 1'b0;
        for (int s = 0; s < STAGE_BYTES; s++) stage[s] = 8'h00;
        for (int k = 0; k < N_CAND; k++) begin
            if (cand_en[k]) begin
                if (!dropped && pos + int'(cand[k].len) <= int'(free)) begin
                    for (int j = 0; j < PKT_BYTES; j++) begin
                        if (j < int'(cand[k].len) && pos + j < STAGE_BYTES)
                            stage[pos + j] = cand[k].data[j*8 +: 8];
                    end
                    pos = pos + int'(cand[k].len);
                end else begin
                    dropped = 1'b1;
                end
            end
        end
        wr_cnt = WC_W'(pos);
        for (int s = 0; s < STAGE_BYTES; s++) wr_data[s*8 +: 8] = stage[s];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q    <= '0;
            last_ok_q <= 1'b0;
            ovf_q     <= 1'b0;
            mode_q    <= 2'd2;
        end else begin
            ovf_q <= dropped;
            if (dropped) begin
                last_ok_q <= 1'b0;
            end else if (cand_en[3]) begin
                last_q    <= ev_tgt;
                last_ok_q <= 1'b1;
            end
            if (mode_chg) mode_q <= ev_mode;
        end
    end

    bt_byte_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WMAX  (STAGE_BYTES)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_cnt    (wr_cnt),
        .wr_data   (wr_data),
        .free      (free),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte)
    );

    // R1
    seq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((!ev_valid || kind == EV_SEQ) && !ovf_q) |-> (wr_cnt == '0));

    // R2
    cond_noaddr_chk: assert property (@(posedge clk) disable iff (rst)
        (is_cond && !ovf_q) |-> (wr_cnt <= WC_W'(1)));

    // R7
    mode_same_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && kind == EV_MODE && ev_mode == mode_q && !ovf_q) |-> (wr_cnt == '0));

    // R8
    ovf_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && wr_cnt != '0) |-> (wr_data[7:0] == 8'h40));

    // R9
    relearn_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> !last_ok_q);

endmodule

// File: tb/sim_bt_trace_gen.sv
`timescale 1ns/1ps
module sim_bt_trace_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = 3'd0;
    logic        ev_taken = 1'b0;
    logic [63:0] ev_src = '0;
    logic [63:0] ev_tgt = '0;
    logic [1:0]  ev_mode = 2'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_byte;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];

    logic [63:0] m_last;
    bit          m_ok;
    logic [5:0]  m_acc;
    int          m_n;
    logic [1:0]  m_mode;

    always #2 clk = ~clk;   // 250 MHz

    bt_trace_gen u0 (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_taken(ev_taken), .ev_src(ev_src), .ev_tgt(ev_tgt), .ev_mode(ev_mode),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
    );

    always @(negedge clk) if (!rst && out_valid && out_ready) got_q.push_back(out_byte);

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // ---- expected-stream model built from the requirements ----
    task automatic m_flush();
        if (m_n > 0) begin
            exp_q.push_back(8'h80 | 8'(1 << m_n) | {2'b00, m_acc});
            m_n = 0; m_acc = '0;
        end
    endtask

    task automatic m_cond(input bit t);
        m_acc = {m_acc[4:0], t};
        m_n++;
        if (m_n == 6) begin
            exp_q.push_back({2'b11, m_acc});
            m_n = 0; m_acc = '0;
        end
    endtask

    task automatic m_addr(input logic [3:0] op, input logic [63:0] a);
        logic [1:0] c;
        int nb;
        if (!m_ok)                          c = 2'd3;
        else if (a == m_last)               c = 2'd0;
        else if (a[63:16] == m_last[63:16]) c = 2'd1;
        else if (a[63:32] == m_last[63:32]) c = 2'd2;
        else                                c = 2'd3;
        nb = (c == 2'd0) ? 0 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 8;
        exp_q.push_back({op, 2'b00, c});
        for (int i = 0; i < nb; i++) exp_q.push_back(a[i*8 +: 8]);
        m_last = a; m_ok = 1;
    endtask

    // ---- drivers ----
    task automatic ev(input logic [2:0] k, input bit t, input logic [63:0] s,
                      input logic [63:0] g, input logic [1:0] md);
        ev_kind = k; ev_taken = t; ev_src = s; ev_tgt = g; ev_mode = md;
        ev_valid = 1'b1;
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    task automatic cond(input bit t);
        ev(3'd1, t, '0, '0, 2'd0); m_cond(t);
    endtask

    task automatic indir(input logic [63:0] g);
        ev(3'd2, 1'b0, '0, g, 2'd0); m_flush(); m_addr(4'd1, g);
    endtask

    task automatic async_e(input logic [63:0] s, input logic [63:0] g);
        ev(3'd3, 1'b0, s, g, 2'd0); m_flush(); m_addr(4'd2, s); m_addr(4'd1, g);
    endtask

    task automatic mode_e(input logic [1:0] md);
        ev(3'd4, 1'b0, '0, '0, md);
        if (md != m_mode && md != 2'd3) begin
            m_flush();
            exp_q.push_back(8'h30);
            exp_q.push_back({6'd0, md});
            m_mode = md;
        end
    endtask

    task automatic drain();
        int idle = 0;
        while (idle < 4) begin
            @(posedge clk); #1;
            if (!out_valid) idle++; else idle = 0;
        end
    endtask

    task automatic cmp(input string tag);
        int n;
        check(got_q.size() == exp_q.size(), {tag, " length"}, got_q.size(), exp_q.size());
        n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
        for (int i = 0; i < n; i++)
            check(got_q[i] === exp_q[i], $sformatf("%s byte %0d", tag, i), got_q[i], exp_q[i]);
        got_q.delete(); exp_q.delete();
    endtask

    task automatic got_at(input string tag, input int idx, input logic [7:0] v);
        if (idx < got_q.size()) check(got_q[idx] === v, tag, got_q[idx], v);
        else check(1'b0, {tag, " missing"}, got_q.size(), idx + 1);
    endtask

    task automatic do_reset();
        rst = 1'b1; ev_valid = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid in reset", out_valid, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        m_ok = 0; m_n = 0; m_acc = '0; m_mode = 2'd2; m_last = '0;
        got_q.delete(); exp_q.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
        @(posedge clk); #1;
    endtask

    // ---- scenarios ----
    task automatic t_quiet_r1();
        do_reset();
        for (int i = 0; i < 5; i++) ev(3'd0, 1'b1, 64'h100 + i, 64'h200 + i, 2'd1);
        repeat (3) @(posedge clk);
        #1;
        cond(1'b1); cond(1'b0); cond(1'b1);
        drain();
        check(got_q.size() == 0, "R1 plain and held bits give no bytes", got_q.size(), 0);
        cmp("R1 stream");
    endtask

    task automatic t_batch_r2();
        do_reset();
        cond(1'b1); cond(1'b0); cond(1'b1); cond(1'b1); cond(1'b0); cond(1'b0);
        for (int i = 0; i < 12; i++) cond(1'b1);
        drain();
        got_at("R2 six-bit batch 101100", 0, 8'hEC);
        got_at("R2 all-taken batch", 1, 8'hFF);
        cmp("R2 stream");
    endtask

    task automatic t_flush_r3();
        do_reset();
        cond(1'b1); cond(1'b1); cond(1'b0);
        indir(64'h1234_5678_9ABC_DEF0);
        drain();
        cond(1'b0);
        mode_e(2'd0);
        drain();
        got_at("R3 partial batch before target", 0, 8'h8E);
        got_at("R4 full target header", 1, 8'h13);
        got_at("R4 low address byte first", 2, 8'hF0);
        got_at("R3 partial batch before mode", 10, 8'h82);
        cmp("R3 stream");
    endtask

    task automatic t_comp_r5();
        do_reset();
        indir(64'h0000_7FFF_1234_5678); drain();
        indir(64'h0000_7FFF_1234_5678); drain();
        indir(64'h0000_7FFF_1234_5687); drain();
        indir(64'h0000_7FFF_9999_5687); drain();
        indir(64'h0000_01FF_9999_5687); drain();
        got_at("R9 first after reset full", 0, 8'h13);
        got_at("R5 same address code 0", 9, 8'h10);
        got_at("R5 two-byte code 1", 10, 8'h11);
        got_at("R5 four-byte code 2", 13, 8'h12);
        got_at("R5 full code 3", 18, 8'h13);
        cmp("R5 stream");
    endtask

    task automatic t_async_r6();
        do_reset();
        indir(64'h4000_0000_0000_1000); drain();
        cond(1'b1);
        async_e(64'h4000_0000_0000_1234, 64'h4000_0000_0000_8000); drain();
        async_e(64'h4000_0000_0000_8000, 64'hFFFF_8000_0000_0000); drain();
        got_at("R3 single bit flush", 9, 8'h83);
        got_at("R6 flow-update first", 10, 8'h21);
        got_at("R6 target after source", 13, 8'h11);
        got_at("R6 source equals reference", 16, 8'h20);
        got_at("R6 far target", 17, 8'h13);
        cmp("R6 stream");
    endtask

    task automatic t_mode_r7();
        do_reset();
        mode_e(2'd2); mode_e(2'd3); mode_e(2'd1); mode_e(2'd1); mode_e(2'd0);
        drain();
        got_at("R7 mode header", 0, 8'h30);
        got_at("R7 mode code 32-bit", 1, 8'h01);
        check(got_q.size() == 4, "R7 unchanged and code 3 silent", got_q.size(), 4);
        cmp("R7 stream");
    endtask

    task automatic t_ovf_r8();
        do_reset();
        out_ready = 1'b0;
        indir(64'h0000_1111_2222_3330);
        indir(64'h0000_1111_2222_3340);
        ev(3'd2, 1'b0, '0, 64'h7777_0000_0000_0000, 2'd0);   // no room: dropped
        m_ok = 0;
        exp_q.push_back(8'h40);
        repeat (2) @(posedge clk);
        #1;
        out_ready = 1'b1;
        drain();
        indir(64'h0000_1111_2222_3340); drain();
        indir(64'h0000_1111_2222_3340); drain();
        got_at("R8 marker after dropped packet", 12, 8'h40);
        got_at("R9 full address after overflow", 13, 8'h13);
        got_at("R9 relearned reference", 22, 8'h10);
        cmp("R8 stream");

        do_reset();
        out_ready = 1'b0;
        indir(64'h0000_0000_ABCD_0000);
        indir(64'h0000_0000_ABCD_000F);
        indir(64'h0000_0000_ABCD_00F0);
        indir(64'h0000_0000_ABCD_00F0);
        ev(3'd2, 1'b0, '0, 64'h5555_0000_0000_0000, 2'd0);   // FIFO full: dropped
        m_ok = 0;
        exp_q.push_back(8'h40);
        repeat (3) @(posedge clk);
        #1;
        out_ready = 1'b1;
        drain();
        check(got_q.size() == 17, "R8 marker waits for room", got_q.size(), 17);
        got_at("R8 marker after full FIFO", 16, 8'h40);
        cmp("R8 full stream");
    endtask

    task automatic t_hold_r10();
        logic [7:0] first;
        do_reset();
        out_ready = 1'b0;
        indir(64'h0102_0304_0506_0708);
        @(negedge clk);
        first = out_byte;
        check(first == 8'h13, "R10 head byte", first, 8'h13);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid && out_byte == first, "R10 hold while stalled", out_byte, first);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain();
        cmp("R10 stream after stall");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        t_quiet_r1();
        t_batch_r2();
        t_flush_r3();
        t_comp_r5();
        t_async_r6();
        t_mode_r7();
        t_ovf_r8();
        t_hold_r10();
        done = 1;
        summary();
        $finish;
    end

endmodule